// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind the serial slave engine of a small non-volatile memory. During a write transaction the engine hands it a word address and then a run of data bytes. The block stores each byte in an eight-entry page buffer at the in-page position given by the address counter. Only the low three bits of that counter advance after a byte, so the page row never changes. A run longer than eight bytes wraps round inside the page, and later bytes replace earlier ones.

When the engine signals the end of the transaction, the block starts a self-timed commit cycle if at least one byte was collected. The cycle lasts a fixed number of system clocks, which stands in for the physical programming time, and `busy` is high for all of it. In the first clocks of the cycle, each buffered position is written once through the array write port. The program-enable level is sampled only when the cycle starts. With that level low, the cycle still runs but writes nothing. In the bidirectional mode, a low enable level makes the whole array read-only: bytes are dropped and no cycle starts. While `busy` is high, all transaction inputs are ignored.

Top module: `pw_page_commit`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0 and `cur_addr` is 0.
- R2: An accepted `addr_stb` loads `cur_addr` from `addr_byte`. Each accepted `data_stb` adds one to `cur_addr[2:0]`, wrapping from 7 to 0, and leaves `cur_addr[ADDR_W-1:3]` unchanged.
- R3: A stop (`stop_stb`) accepted with at least one buffered byte, outside the protected mode, raises `busy` on the next clock. `busy` then stays high for exactly `CYCLE_CLKS` clocks.
- R4: During the cycle, every in-page position written in the transaction is written exactly once, at address {row, position}. Positions not written in the transaction get no write, so they keep their old contents.
- R5: When more than eight bytes are sent, each position holds the last byte sent to it, and the commit makes eight writes.
- R6: A stop with no data byte since the address load starts no cycle, makes no write, and leaves `cur_addr` at the loaded address.
- R7: If `prog_en` is 0 when the cycle starts and `bidir_mode` is 0, the cycle runs for its full length but makes no array write.
- R8: If `prog_en` was 1 at the start of a cycle and falls during it, the commit is still made in full.
- R9: With `bidir_mode`=1 and `prog_en`=0 (protected mode), data bytes and stops never raise `busy` and never cause an array write.
- R10: While `busy` is 1, `addr_stb`, `data_stb` and `stop_stb` are ignored. `cur_addr` does not change, no further cycle follows, and nothing sent in that time is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_stb | input | 1 | Word address byte valid, one clock |
| addr_byte | input | ADDR_W | Word address |
| data_stb | input | 1 | Data byte valid, one clock |
| data_byte | input | 8 | Data byte |
| stop_stb | input | 1 | Transaction end, one clock |
| prog_en | input | 1 | Program-enable level |
| bidir_mode | input | 1 | Bidirectional mode select |
| busy | output | 1 | Commit cycle in progress |
| cur_addr | output | ADDR_W | Current word address counter |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The hardest case to reach is a second transaction that arrives while a commit cycle is still running. It only makes sense if a real page commit is in flight and its window is known. The bench therefore starts a valid two-byte write, then sends a full address, data and stop sequence while `busy` is high. It checks that the address counter did not move, that no second cycle follows, and that the target byte of the ignored sequence was never written. The wrap case is reached with a ten-byte run that starts in mid-page, so both the boundary crossing and the overwrite of earlier positions happen in one transaction.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COMMIT = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;

  // Advance only the in-page bits of an address, keeping the row.
  function automatic logic [15:0] step_in_page(logic [15:0] a, int unsigned page_w);
    logic [15:0] m;
    m = 16'((32'd1 << page_w) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  // Number of distinct positions touched by n bytes in a page.
  function automatic int unsigned touched(int unsigned n, int unsigned page_bytes);
    return (n > page_bytes) ? page_bytes : n;
  endfunction

endpackage

// File: rtl/pw_addr_ctr.sv
module pw_addr_ctr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  import pw_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (step) begin
      addr <= ADDR_W'(step_in_page(16'(addr), PAGE_W));
    end
  end

  AST_ROW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]))); // R2

endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [PAGE_W-1:0]     wr_pos,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  clr,
  input  logic [PAGE_W-1:0]     rd_pos,
  output logic [DATA_W-1:0]     rd_data,
  output logic [PAGE_BYTES-1:0] mask
);

  logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      mask   <= '0;
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (clr) begin
          mask[i] <= 1'b0;
        end else if (wr && (wr_pos == PAGE_W'(i))) begin
          mask[i]   <= 1'b1;
          slot_q[i] <= wr_data;
        end
      end
    end
  end

  assign rd_data = slot_q[rd_pos];

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !clr) |=> $stable(mask)); // R4

endmodule

// File: rtl/pw_commit_timer.sv
module pw_commit_timer #(
  parameter int CYCLE_CLKS = 500000,
  parameter int PAGE_W     = 3,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int CNT_W      = $clog2(CYCLE_CLKS + 1),
  localparam int LAST       = CYCLE_CLKS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en_in,
  output logic              busy,
  output logic              en_lat,
  output logic              slot_vld,
  output logic [PAGE_W-1:0] slot,
  output logic              done
);
  import pw_pkg::*;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      en_lat  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_COMMIT;
            cnt_q   <= '0;
            en_lat  <= en_in;
          end
        end
        PH_COMMIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(PAGE_BYTES - 1)) phase_q <= PH_SETTLE;
        end
        PH_SETTLE: begin
          if (cnt_q == CNT_W'(LAST)) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign slot_vld = (phase_q == PH_COMMIT);
  assign slot     = cnt_q[PAGE_W-1:0];
  assign done     = (phase_q == PH_SETTLE) && (cnt_q == CNT_W'(LAST));

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= CNT_W'(LAST))); // R3
  AST_COMMIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |-> (cnt_q < CNT_W'(PAGE_BYTES))); // R4
  AST_ENLAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(en_lat)); // R8

endmodule

// File: rtl/pw_page_commit.sv
module pw_page_commit #(
  parameter int ADDR_W     = 8,
  parameter int CYCLE_CLKS = 500000,
  localparam int PAGE_W    = 3,
  localparam int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] addr_byte,
  input  logic              data_stb,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              stop_stb,
  input  logic              prog_en,
  input  logic              bidir_mode,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  // Named internal events
  logic                  protect;
  logic                  accept;
  logic                  load_evt;
  logic                  byte_evt;
  logic                  keep_evt;
  logic                  stop_evt;
  logic                  start_evt;
  logic                  done;
  logic                  buf_clr;
  logic                  en_lat;
  logic                  slot_vld;
  logic [PAGE_W-1:0]     slot;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     slot_data;

  assign protect   = bidir_mode && !prog_en;
  assign accept    = !busy;
  assign load_evt  = accept && addr_stb;
  assign byte_evt  = accept && data_stb && !addr_stb;
  assign keep_evt  = byte_evt && !protect;
  assign stop_evt  = accept && stop_stb && !addr_stb && !data_stb;
  assign start_evt = stop_evt && (|mask) && !protect;
  assign buf_clr   = load_evt || (stop_evt && !start_evt) || done;

  pw_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .load_val (addr_byte),
    .step     (byte_evt),
    .addr     (cur_addr)
  );

  pw_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (keep_evt),
    .wr_pos  (cur_addr[PAGE_W-1:0]),
    .wr_data (data_byte),
    .clr     (buf_clr),
    .rd_pos  (slot),
    .rd_data (slot_data),
    .mask    (mask)
  );

  pw_commit_timer #(.CYCLE_CLKS(CYCLE_CLKS), .PAGE_W(PAGE_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .en_in    (prog_en),
    .busy     (busy),
    .en_lat   (en_lat),
    .slot_vld (slot_vld),
    .slot     (slot),
    .done     (done)
  );

  assign arr_we    = slot_vld && en_lat && mask[slot];
  assign arr_addr  = {cur_addr[ADDR_W-1:PAGE_W], slot};
  assign arr_wdata = slot_data;

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy); // R4
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr)); // R10
  AST_PROT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (protect && !busy) |=> !busy); // R9
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && (mask == '0)) |=> !busy); // R6

endmodule

// File: tb/test_pw_page_commit.sv
module test_pw_page_commit;
  localparam int ADDR_W = 8;
  localparam int CYC    = 20;

  logic              clk;
  logic              rst_n;
  logic              addr_stb;
  logic [ADDR_W-1:0] addr_byte;
  logic              data_stb;
  logic [7:0]        data_byte;
  logic              stop_stb;
  logic              prog_en;
  logic              bidir_mode;
  logic              busy;
  logic [ADDR_W-1:0] cur_addr;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0]        arr_wdata;

  int n_tests;
  int n_fail;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  int         wr_cnt;

  pw_page_commit #(.ADDR_W(ADDR_W), .CYCLE_CLKS(CYC)) i_pw_page_commit (
    .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr_byte(addr_byte),
    .data_stb(data_stb), .data_byte(data_byte), .stop_stb(stop_stb),
    .prog_en(prog_en), .bidir_mode(bidir_mode), .busy(busy), .cur_addr(cur_addr),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Array model: record every write the block makes
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      wr_cnt <= 0;
    end else if (arr_we) begin
      mem[arr_addr] <= arr_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_addr(logic [7:0] a);
    @(negedge clk); addr_stb = 1'b1; addr_byte = a;
    @(negedge clk); addr_stb = 1'b0;
  endtask

  task automatic pulse_data(logic [7:0] d);
    @(negedge clk); data_stb = 1'b1; data_byte = d;
    @(negedge clk); data_stb = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0;
  endtask

  task automatic check_page(logic [7:0] a, string req);
    for (int p = 0; p < 8; p++) begin
      check(req, int'(mem[{a[7:3], 3'(p)}]), int'(exp_mem[{a[7:3], 3'(p)}]));
    end
  endtask

  // One write transaction, checked against the bench's own page model
  task automatic run_case(logic [7:0] a, int n, logic [7:0] seed, logic bidir,
                          logic en, logic drop, logic exp_busy, logic exp_wr,
                          string req);
    int base;
    int busy_n;
    int pos;
    logic [7:0] d;
    bidir_mode = bidir;
    prog_en    = en;
    base       = wr_cnt;
    pulse_addr(a);
    check("R2 load", int'(cur_addr), int'(a));
    pos = int'(a[2:0]);
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 7);
      pulse_data(d);
      if (exp_wr) exp_mem[{a[7:3], 3'(pos)}] = d;
      pos = (pos + 1) & 7;
    end
    check("R2 step", int'(cur_addr), int'({a[7:3], 3'(pos)}));
    pulse_stop();
    if (drop) prog_en = 1'b0;
    busy_n = 0;
    while (busy && busy_n < 4 * CYC) begin
      busy_n++;
      @(negedge clk);
    end
    check({req, " R3 busy length"}, busy_n, exp_busy ? CYC : 0);
    check({req, " write count"}, wr_cnt - base,
          exp_wr ? int'(pw_pkg::touched(n, 8)) : 0);
    check_page(a, {req, " page contents"});
    prog_en    = 1'b1;
    bidir_mode = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 arr_we", int'(arr_we), 0);
    check("R1 cur_addr", int'(cur_addr), 0);
  endtask

  task automatic t_empty_stop();
    int base;
    base = wr_cnt;
    pulse_addr(8'h33);
    pulse_stop();
    check("R6 busy", int'(busy), 0);
    @(negedge clk);
    check("R6 busy later", int'(busy), 0);
    check("R6 cur_addr", int'(cur_addr), 8'h33);
    check("R6 write count", wr_cnt - base, 0);
  endtask

  task automatic t_busy_block();
    logic [7:0] held;
    int base;
    run_case(8'h61, 0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 setup");
    prog_en = 1'b1;
    pulse_addr(8'h61);
    pulse_data(8'hA1); exp_mem[8'h61] = 8'hA1;
    pulse_data(8'hA2); exp_mem[8'h62] = 8'hA2;
    base = wr_cnt;
    pulse_stop();
    check("R10 busy started", int'(busy), 1);
    held = cur_addr;
    pulse_addr(8'h90);
    pulse_data(8'hEE);
    pulse_stop();
    check("R10 cur_addr held", int'(cur_addr), int'(held));
    while (busy) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check("R10 no second cycle", int'(busy), 0);
    end
    check("R10 blocked byte", int'(mem[8'h90]), int'(exp_mem[8'h90]));
    check("R10 write count", wr_cnt - base, 2);
    check_page(8'h61, "R10 page");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    rst_n = 1'b0; addr_stb = 1'b0; addr_byte = '0; data_stb = 1'b0;
    data_byte = '0; stop_stb = 1'b0; prog_en = 1'b1; bidir_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R5: ten bytes from mid-page wrap and overwrite
    run_case(8'h2D, 10, 8'h10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R5");
    // R4: partial write leaves other positions of the same page intact
    run_case(8'h2A, 3, 8'hC0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4");
    t_empty_stop();
    // R7: enable low at start, not protected: timed cycle, no writes
    run_case(8'h50, 4, 8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    // R8: enable falls after start: commit still made
    run_case(8'h58, 5, 8'h77, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
    // R9: protected mode: no cycle, no writes
    run_case(8'h70, 3, 8'h55, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    t_busy_block();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule